// File: doc/BRIEF.md
# SMBus Clock-Low Timeout Monitor

This block guards the clock line of a bus slave that answers an external master. It measures how long the serial clock stays low without a break. When the low time reaches a fixed 30 milliseconds, it raises a timeout flag so that firmware can reinitialise the slave logic. It can also emit a single-cycle request that resets the slave logic directly.

The raw clock line passes through a two-flop synchronizer. A prescaler turns the system clock into millisecond steps, and a saturating counter totals whole milliseconds. Counting is allowed only while the compatibility mode is switched on and the slave reports that it is busy. In every other case the count is held at zero. A clock-high level also restarts the count, so a slow but legal transfer never accumulates time across separate low phases.

All pins are plain level controls or status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure rule. The flag stays set until firmware clears it. The enable and idle inputs are taken as already synchronous to the system clock.

Top module: `smb_lowtime_guard`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it is released, `to_irq` and `to_rst_pulse` are 0.
- R2: Let `smb_en`=1 and `slave_idle`=0, and let rising edge E0 be the first edge to sample `scl_raw` low. `to_irq` is 0 through edge E0+LIMIT_MS*CLK_PER_MS and is 1 after edge E0+LIMIT_MS*CLK_PER_MS+1. This is two synchronizer cycles plus LIMIT_MS*CLK_PER_MS counting cycles.
- R3: If `scl_raw` is sampled high on one edge Eh, the accumulated low time is discarded. The flag then rises after edge Eh+2+LIMIT_MS*CLK_PER_MS, provided the line is low again from edge Eh+1.
- R4: If `smb_en` is 0 at a rising edge Ea, the count is cleared on that edge. With `smb_en` held at 0, the flag never rises however long the line stays low. If counting resumes right after Ea, the flag rises after edge Ea+LIMIT_MS*CLK_PER_MS.
- R5: `slave_idle`=1 at a rising edge clears the count in the same way as R4, with the same timing and the same "never fires" behaviour.
- R6: Once set, `to_irq` stays 1 after the line returns high, until it is cleared.
- R7: `to_clr`=1 at an edge drives `to_irq` to 0 after that edge. If the timeout expires on that same edge, the set wins and `to_irq` stays 1.
- R8: The flag fires at most once per continuous low period. After a clear, a line that stays low does not set it again.
- R9: With EN_RST_PULSE=1, `to_rst_pulse` is 1 for exactly one cycle, after the same edge on which `to_irq` is set by an expiry. With EN_RST_PULSE=0 it is tied to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_raw | input | 1 | Unsynchronized slave clock line level |
| smb_en | input | 1 | 1 = timeout mode on |
| slave_idle | input | 1 | 1 = slave idle with no bus traffic |
| to_clr | input | 1 | Clears the timeout flag |
| to_irq | output | 1 | Sticky timeout interrupt flag |
| to_rst_pulse | output | 1 | One-cycle slave reset request on expiry |

## Verification
The flag and the reset pulse appear LIMIT_MS*CLK_PER_MS+1 edges after the first edge that samples the line low. A restart caused by the line going high adds two edges, because the high level must cross the synchronizer. A gating input or a clear acts on the very next edge. The driver computes each due cycle from these counts and queues it with the expected levels. The monitor compares each queued item on the falling edge that follows its due edge. It also checks the edge just before each rise, so an early firing is caught as well as a late one.

// File: rtl/smbto_pkg.sv
package smbto_pkg;
  localparam int SMBTO_SYNC_STAGES = 2;

  function automatic int cnt_width(input int maxv);
    return (maxv <= 1) ? 1 : $clog2(maxv + 1);
  endfunction
endpackage

// File: rtl/smbto_sync.sv
module smbto_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/smbto_prescale.sv
module smbto_prescale #(
  parameter int DIV = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  import smbto_pkg::*;
  localparam int PW = cnt_width(DIV - 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_cnt;

  assign tick = run && (pre_cnt == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pre_cnt <= '0;
    else if (!run || tick)  pre_cnt <= '0;
    else                    pre_cnt <= pre_cnt + 1'b1;
  end
endmodule

// File: rtl/smbto_mscount.sv
module smbto_mscount #(
  parameter int LIMIT = 30,
  parameter int MW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  output logic [MW-1:0] ms_cnt,
  output logic          expire
);
  localparam logic [MW-1:0] MS_SAT  = MW'(LIMIT);
  localparam logic [MW-1:0] MS_LAST = MW'(LIMIT - 1);

  assign expire = run && tick && (ms_cnt == MS_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ms_cnt <= '0;
    else if (!run)                   ms_cnt <= '0;
    else if (tick && ms_cnt != MS_SAT) ms_cnt <= ms_cnt + 1'b1;
  end
endmodule

// File: rtl/smbto_flag.sv
module smbto_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/smb_lowtime_guard.sv
module smb_lowtime_guard #(
  parameter int CLK_PER_MS   = 125000,
  parameter int LIMIT_MS     = 30,
  parameter bit EN_RST_PULSE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic smb_en,
  input  logic slave_idle,
  input  logic to_clr,
  output logic to_irq,
  output logic to_rst_pulse
);
  import smbto_pkg::*;
  localparam int MW = cnt_width(LIMIT_MS);

  logic          scl_s;
  logic          run;
  logic          tick;
  logic          expire;
  logic [MW-1:0] ms_cnt;

  smbto_sync #(.STAGES(SMBTO_SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_raw), .q(scl_s)
  );

  // Counting is allowed only for a busy slave in timeout mode with the line low
  assign run = smb_en && !slave_idle && !scl_s;

  smbto_prescale #(.DIV(CLK_PER_MS)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  smbto_mscount #(.LIMIT(LIMIT_MS), .MW(MW)) u_ms (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .ms_cnt(ms_cnt), .expire(expire)
  );

  smbto_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set(expire), .clr(to_clr), .flag(to_irq)
  );

  generate
    if (EN_RST_PULSE) begin : g_pulse
      logic pulse_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= expire;
      end
      assign to_rst_pulse = pulse_q;
    end else begin : g_nopulse
      assign to_rst_pulse = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/smbto_chk.sv
module smbto_chk #(
  parameter int LIMIT_MS = 30,
  parameter int MW       = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          smb_en,
  input logic          slave_idle,
  input logic          to_clr,
  input logic          to_irq,
  input logic          to_rst_pulse,
  input logic [MW-1:0] ms_cnt,
  input logic          expire
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!to_irq && !to_rst_pulse)) else $error("reset"); // R1
  AST_RISE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_irq) |-> ($past(ms_cnt) == MW'(LIMIT_MS - 1))) else $error("rise"); // R2
  AST_HIGH_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    scl_s |=> (ms_cnt == '0)) else $error("restart"); // R3
  AST_MODE_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !smb_en |=> (ms_cnt == '0)) else $error("mode"); // R4
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    slave_idle |=> (ms_cnt == '0)) else $error("idle"); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (to_irq && !to_clr) |=> to_irq) else $error("sticky"); // R6
  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> to_irq) else $error("setwins"); // R7
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ms_cnt <= MW'(LIMIT_MS)) else $error("bound"); // R8
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    to_rst_pulse |=> !to_rst_pulse) else $error("pulse"); // R9
  AST_PULSE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    to_rst_pulse |-> to_irq) else $error("pulseflag"); // R9
endmodule

bind smb_lowtime_guard smbto_chk #(.LIMIT_MS(LIMIT_MS), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .smb_en(smb_en),
  .slave_idle(slave_idle), .to_clr(to_clr), .to_irq(to_irq),
  .to_rst_pulse(to_rst_pulse), .ms_cnt(ms_cnt), .expire(expire)
);

// File: tb/smb_lowtime_guard_test.sv
module smb_lowtime_guard_test;
  localparam int P  = 8;
  localparam int L  = 30;
  localparam int LP = P * L;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_raw = 1'b1;
  logic smb_en = 1'b0;
  logic slave_idle = 1'b1;
  logic to_clr = 1'b0;
  logic to_irq;
  logic to_rst_pulse;

  int cyc = 0;
  int checks = 0;
  int failures = 0;

  typedef struct {
    int    at;
    logic  irq;
    logic  chk_pulse;
    logic  pulse;
    string req;
  } exp_t;
  exp_t sbq[$];

  smb_lowtime_guard #(.CLK_PER_MS(P), .LIMIT_MS(L), .EN_RST_PULSE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_raw), .smb_en(smb_en),
    .slave_idle(slave_idle), .to_clr(to_clr), .to_irq(to_irq),
    .to_rst_pulse(to_rst_pulse)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int at, logic irq, logic chkp, logic pulse, string req);
    exp_t e;
    e.at = at; e.irq = irq; e.chk_pulse = chkp; e.pulse = pulse; e.req = req;
    sbq.push_back(e);
  endtask

  task automatic wait_until(int t);
    while (cyc < t) @(negedge clk);
  endtask

  // Monitor: compares queued expectations on the falling edge after their due edge
  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].at == cyc) begin
        checks++;
        if (to_irq !== sbq[i].irq || (sbq[i].chk_pulse && to_rst_pulse !== sbq[i].pulse)) begin
          failures++;
          $display("FAIL %s cyc=%0d irq=%b pulse=%b expected irq=%b pulse=%b",
                   sbq[i].req, cyc, to_irq, to_rst_pulse, sbq[i].irq, sbq[i].pulse);
        end
        sbq.delete(i);
      end else if (sbq[i].at < cyc) begin
        checks++;
        failures++;
        $display("FAIL %s missed at=%0d actual=none expected=sampled", sbq[i].req, sbq[i].at);
        sbq.delete(i);
      end
    end
  end

  task automatic rest_and_clear();
    scl_raw = 1'b1;
    wait_until(cyc + 4);
    to_clr = 1'b1;
    expect_at(cyc + 1, 1'b0, 1'b1, 1'b0, "R7");
    @(negedge clk);
    to_clr = 1'b0;
    wait_until(cyc + 3);
  endtask

  initial begin
    int c0;
    int eh;
    int ea;
    @(negedge clk);
    expect_at(cyc + 1, 1'b0, 1'b1, 1'b0, "R1");
    wait_until(cyc + 3);
    rst_n = 1'b1;
    expect_at(cyc + 1, 1'b0, 1'b1, 1'b0, "R1");
    smb_en = 1'b1;
    slave_idle = 1'b0;
    wait_until(cyc + 4);

    // R2, R9: basic expiry timing
    scl_raw = 1'b0;
    c0 = cyc + 1;
    expect_at(c0 + LP, 1'b0, 1'b1, 1'b0, "R2");
    expect_at(c0 + LP + 1, 1'b1, 1'b1, 1'b1, "R2");
    expect_at(c0 + LP + 2, 1'b1, 1'b1, 1'b0, "R9");
    wait_until(c0 + LP + 4);
    // R8: clear while still low, no refire
    to_clr = 1'b1;
    expect_at(cyc + 1, 1'b0, 1'b1, 1'b0, "R7");
    @(negedge clk);
    to_clr = 1'b0;
    expect_at(cyc + 2 * LP, 1'b0, 1'b1, 1'b0, "R8");
    wait_until(cyc + 2 * LP + 2);

    // R6: sticky after line returns high
    scl_raw = 1'b1;
    wait_until(cyc + 4);
    scl_raw = 1'b0;
    c0 = cyc + 1;
    expect_at(c0 + LP + 1, 1'b1, 1'b1, 1'b1, "R6");
    wait_until(c0 + LP + 3);
    scl_raw = 1'b1;
    expect_at(cyc + 20, 1'b1, 1'b1, 1'b0, "R6");
    wait_until(cyc + 22);
    rest_and_clear();

    // R3: high level mid-count restarts
    scl_raw = 1'b0;
    c0 = cyc + 1;
    wait_until(c0 + LP - 10);
    scl_raw = 1'b1;
    eh = cyc + 1;
    @(negedge clk);
    scl_raw = 1'b0;
    expect_at(c0 + LP + 1, 1'b0, 1'b1, 1'b0, "R3");
    expect_at(eh + 1 + LP, 1'b0, 1'b1, 1'b0, "R3");
    expect_at(eh + 2 + LP, 1'b1, 1'b1, 1'b1, "R3");
    wait_until(eh + LP + 4);
    rest_and_clear();

    // R4: mode off for one edge mid-count
    scl_raw = 1'b0;
    c0 = cyc + 1;
    wait_until(c0 + 100);
    smb_en = 1'b0;
    ea = cyc + 1;
    @(negedge clk);
    smb_en = 1'b1;
    expect_at(ea + LP - 1, 1'b0, 1'b1, 1'b0, "R4");
    expect_at(ea + LP, 1'b1, 1'b1, 1'b1, "R4");
    wait_until(ea + LP + 3);
    rest_and_clear();

    // R4: mode held off, never fires
    smb_en = 1'b0;
    scl_raw = 1'b0;
    expect_at(cyc + 3 * LP, 1'b0, 1'b1, 1'b0, "R4");
    wait_until(cyc + 3 * LP + 2);
    scl_raw = 1'b1;
    smb_en = 1'b1;
    wait_until(cyc + 4);

    // R5: idle pulse mid-count
    scl_raw = 1'b0;
    c0 = cyc + 1;
    wait_until(c0 + 60);
    slave_idle = 1'b1;
    ea = cyc + 1;
    @(negedge clk);
    slave_idle = 1'b0;
    expect_at(ea + LP - 1, 1'b0, 1'b1, 1'b0, "R5");
    expect_at(ea + LP, 1'b1, 1'b1, 1'b1, "R5");
    wait_until(ea + LP + 3);
    rest_and_clear();

    // R5: idle held, never fires
    slave_idle = 1'b1;
    scl_raw = 1'b0;
    expect_at(cyc + 3 * LP, 1'b0, 1'b1, 1'b0, "R5");
    wait_until(cyc + 3 * LP + 2);
    scl_raw = 1'b1;
    slave_idle = 1'b0;
    wait_until(cyc + 4);

    // R7: set wins over a clear on the expiry edge
    scl_raw = 1'b0;
    c0 = cyc + 1;
    wait_until(c0 + LP);
    to_clr = 1'b1;
    expect_at(c0 + LP + 1, 1'b1, 1'b1, 1'b1, "R7");
    @(negedge clk);
    to_clr = 1'b0;
    expect_at(c0 + LP + 5, 1'b1, 1'b1, 1'b0, "R7");
    wait_until(c0 + LP + 7);
    rest_and_clear();

    wait_until(cyc + 4);
    if (sbq.size() != 0) begin
      failures++;
      $display("FAIL R1 pending=%0d expected=0", sbq.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    failures++;
    $display("FAIL watchdog cyc=%0d expected=finished", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule